// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline and picks the address that fetch uses next. It compares the two register operands of a branch (equal or not equal, as the decoded type asks) and adds the sign-extended word offset to the address of the instruction after the branch. That address is the PC that fetch holds now. Because both the comparison and the target adder sit in decode, a taken branch redirects fetch on the next clock edge. At most one wrongly fetched instruction is ever in flight.

A parameter selects the policy for that one instruction. With `DELAY_SLOT = 0` the pipeline predicts not taken. A taken branch raises `squash`, and the surrounding pipeline turns the IF/ID register into a NOP on the next edge. With `DELAY_SLOT = 1` the instruction after the branch is an architectural delay slot: it always executes and `squash` never rises. Every pin is a plain control or data pin with no valid/ready handshake. The unit has no back-pressure of its own: a `stall` input freezes it, and its outputs follow their inputs in the same cycle.

Top module: `dec_branch_resolver`

## Requirements
- R1: With branch type code 2'b01 (equal) in decode, not stalled, not masked, and the operands equal, `next_pc` is `fetch_pc` plus the offset sign-extended and shifted left by two.
- R2: With branch type code 2'b10 (not equal) in decode, not stalled, not masked, and the operands unequal, `next_pc` is the same branch target as in R1.
- R3: A branch whose condition fails selects `fetch_pc + 4` and leaves `squash` low, so it costs no cycle.
- R4: With `DELAY_SLOT = 0`, a taken branch raises `squash` in the same cycle that it redirects `next_pc`.
- R5: With `DELAY_SLOT = 1`, `squash` never rises, and a taken branch still redirects `next_pc` to its target.
- R6: Type codes 2'b00 and 2'b11 are non-branches. They select `fetch_pc + 4` and never raise `squash`.
- R7: While `stall` is high, `next_pc` equals `fetch_pc` and `squash` is low, whatever the branch inputs are.
- R8: In the cycle after a clock edge on which `squash` was high, the decode contents are a bubble. The branch type is ignored, so `next_pc` is `fetch_pc + 4` and `squash` is low. A stalled cycle keeps this mask.
- R9: Address arithmetic wraps modulo 2^AW. Negative offsets move the target backwards.
- R10: While reset is held and after it is released, the bubble mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Freezes the pipeline front end; no redirect or squash while high |
| fetch_pc | input | AW | Address of the instruction now in fetch (branch address + 4) |
| dec_br_type | input | 2 | 01 equal, 10 not equal, 00/11 no branch |
| opnd_a | input | DW | First register operand |
| opnd_b | input | DW | Second register operand |
| dec_offset | input | OW | Signed word offset of the branch |
| next_pc | output | AW | Address fetch uses on the next edge |
| squash | output | 1 | Turns the IF/ID register into a NOP on the next edge |

## Verification
`next_pc` and `squash` are combinational in the inputs and in one mask register. Each is therefore due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples one nanosecond later, well before the rising edge. The R8 bubble mask takes effect one rising edge after a squash. The bench's model updates its own copy of the mask only after that edge, so the following stimulus is checked against it. Two instances, one per policy, see identical stimulus.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [1:0] {
    BT_NONE = 2'b00,
    BT_EQ   = 2'b01,
    BT_NE   = 2'b10,
    BT_RSV  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/brr_compare.sv
module brr_compare
  import brr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    kind,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          taken
);
  logic same;
  assign same = (a == b);

  always_comb begin
    case (kind)
      BT_EQ:   taken = same;
      BT_NE:   taken = !same;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brr_target.sv
module brr_target #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] base_pc,
  input  logic [OW-1:0] word_off,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] tgt_pc
);
  localparam int EXTW = AW - 2 - OW;
  logic [AW-1:0] byte_off;

  generate
    if (EXTW > 0) begin : g_ext
      assign byte_off = {{EXTW{word_off[OW-1]}}, word_off, 2'b00};
    end else begin : g_trunc
      assign byte_off = {word_off[AW-3:0], 2'b00};
    end
  endgenerate

  assign seq_pc = base_pc + AW'(4);
  assign tgt_pc = base_pc + byte_off;
endmodule

// File: rtl/brr_select.sv
module brr_select #(
  parameter int AW         = 32,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic          redirect,
  input  logic          hold,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] tgt_pc,
  output logic [AW-1:0] pick_pc,
  output logic          kill
);
  always_comb begin
    if (hold)          pick_pc = cur_pc;
    else if (redirect) pick_pc = tgt_pc;
    else               pick_pc = seq_pc;
  end

  generate
    if (DELAY_SLOT) begin : g_slot
      assign kill = 1'b0;
    end else begin : g_pnt
      assign kill = redirect && !hold;
    end
  endgenerate
endmodule

// File: rtl/dec_branch_resolver.sv
module dec_branch_resolver
  import brr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int OW         = 16,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [AW-1:0] fetch_pc,
  input  logic [1:0]    dec_br_type,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [OW-1:0] dec_offset,
  output logic [AW-1:0] next_pc,
  output logic          squash
);
  logic          bubble_q;
  logic [1:0]    eff_kind;
  logic          cond_taken;
  logic [AW-1:0] seq_pc, tgt_pc;

  // a squashed IF/ID holds a NOP: mask whatever type is presented
  assign eff_kind = bubble_q ? 2'(BT_NONE) : dec_br_type;

  brr_compare #(.DW(DW)) u_cmp (
    .kind (eff_kind),
    .a    (opnd_a),
    .b    (opnd_b),
    .taken(cond_taken)
  );

  brr_target #(.AW(AW), .OW(OW)) u_tgt (
    .base_pc (fetch_pc),
    .word_off(dec_offset),
    .seq_pc  (seq_pc),
    .tgt_pc  (tgt_pc)
  );

  brr_select #(.AW(AW), .DELAY_SLOT(DELAY_SLOT)) u_sel (
    .redirect(cond_taken),
    .hold    (stall),
    .cur_pc  (fetch_pc),
    .seq_pc  (seq_pc),
    .tgt_pc  (tgt_pc),
    .pick_pc (next_pc),
    .kill    (squash)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bubble_q <= 1'b0;
    else if (!stall) bubble_q <= squash;
  end
endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
  parameter int AW         = 32,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic [AW-1:0] fetch_pc,
  input logic [1:0]    dec_br_type,
  input logic [AW-1:0] next_pc,
  input logic          squash
);
  a_r4_squash_only_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> ((dec_br_type == 2'b01 || dec_br_type == 2'b10) && !stall));

  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (next_pc == fetch_pc && !squash));

  a_r8_no_back_to_back_squash: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !squash);

  a_r5_slot_never_squashed: assert property (@(posedge clk) disable iff (!rst_n)
    DELAY_SLOT |-> !squash);

  a_r6_nonbranch_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_br_type == 2'b00 || dec_br_type == 2'b11) && !stall)
      |-> (next_pc == fetch_pc + AW'(4) && !squash));
endmodule

bind dec_branch_resolver brr_checker #(.AW(AW), .DELAY_SLOT(DELAY_SLOT)) u_brr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .fetch_pc   (fetch_pc),
  .dec_br_type(dec_br_type),
  .next_pc    (next_pc),
  .squash     (squash)
);

// File: tb/test_dec_branch_resolver.sv
`timescale 1ns/1ps
module test_dec_branch_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] fetch_pc = 32'h0;
  logic [1:0]  br_type = 2'b00;
  logic [31:0] op_a = 32'h0, op_b = 32'h0;
  logic [15:0] off = 16'h0;
  logic [31:0] npc_p, npc_d;
  logic        sq_p, sq_d;
  int          checks = 0, errors = 0;
  logic        bub_p = 1'b0, bub_d = 1'b0;

  always #4 clk = ~clk;

  dec_branch_resolver #(.DELAY_SLOT(1'b0)) i_dec_branch_resolver (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_pc(fetch_pc),
    .dec_br_type(br_type), .opnd_a(op_a), .opnd_b(op_b), .dec_offset(off),
    .next_pc(npc_p), .squash(sq_p));

  dec_branch_resolver #(.DELAY_SLOT(1'b1)) i_dec_branch_resolver_ds (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_pc(fetch_pc),
    .dec_br_type(br_type), .opnd_a(op_a), .opnd_b(op_b), .dec_offset(off),
    .next_pc(npc_d), .squash(sq_d));

  function automatic logic cond(logic [1:0] t, logic [31:0] a, logic [31:0] b);
    return (t == 2'b01 && a == b) || (t == 2'b10 && a != b);
  endfunction

  function automatic logic [31:0] target(logic [31:0] pc, logic [15:0] o);
    return pc + ({{16{o[15]}}, o} << 2);
  endfunction

  function automatic string tag_of(logic st, logic bub, logic [1:0] t, logic tk, logic ds);
    if (st) return "R7";
    if (bub) return "R8";
    if (t == 2'b00 || t == 2'b11) return "R6";
    if (!tk) return "R3";
    if (ds) return "R5";
    return (t == 2'b01) ? "R1" : "R2";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, check 1 ns later, update bubble model after rising edge
  task automatic step(logic st, logic [1:0] t, logic [31:0] a, logic [31:0] b,
                      logic [15:0] o, logic [31:0] pc, string extra);
    logic tk_p, tk_d, esq_p;
    logic [31:0] en_p, en_d;
    @(negedge clk);
    stall = st; br_type = t; op_a = a; op_b = b; off = o; fetch_pc = pc;
    #1;
    tk_p = cond(t, a, b) && !bub_p && !st;
    tk_d = cond(t, a, b) && !bub_d && !st;
    en_p = st ? pc : (tk_p ? target(pc, o) : pc + 32'd4);
    en_d = st ? pc : (tk_d ? target(pc, o) : pc + 32'd4);
    esq_p = tk_p;
    chk({tag_of(st, bub_p, t, cond(t, a, b), 1'b0), extra, " pnt next_pc"}, npc_p, en_p);
    chk({tag_of(st, bub_p, t, cond(t, a, b), 1'b0), " R4 pnt squash"}, {31'b0, sq_p}, {31'b0, esq_p});
    chk({tag_of(st, bub_d, t, cond(t, a, b), 1'b1), extra, " ds next_pc"}, npc_d, en_d);
    chk({"R5 ds squash"}, {31'b0, sq_d}, 32'b0);
    @(posedge clk);
    #0.1;
    if (!st) begin
      bub_p = esq_p;
      bub_d = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4611);
    // R10 reset: mask clear, plain fetch-plus-four
    br_type = 2'b01; op_a = 32'h5; op_b = 32'h9; fetch_pc = 32'h100;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 reset next_pc", npc_p, 32'h104);
    chk("R10 reset squash", {31'b0, sq_p}, 32'b0);
    rst_n = 1'b1;
    @(posedge clk);

    step(1'b0, 2'b01, 32'h7, 32'h7, 16'h0010, 32'h1000, " R1 eq taken");
    step(1'b0, 2'b01, 32'h7, 32'h7, 16'h0010, 32'h1004, " R8 masked after squash");
    step(1'b0, 2'b01, 32'h7, 32'h8, 16'h0010, 32'h2000, " R3 eq not taken");
    step(1'b0, 2'b10, 32'h1, 32'h0, 16'h0020, 32'h3000, " R2 ne taken");
    step(1'b1, 2'b10, 32'h1, 32'h0, 16'h0020, 32'h3100, " R7 stall after squash");
    step(1'b0, 2'b10, 32'h1, 32'h0, 16'h0020, 32'h3100, " R8 mask held over stall");
    step(1'b0, 2'b10, 32'h3, 32'h3, 16'h0020, 32'h4000, " R3 ne not taken");
    step(1'b0, 2'b11, 32'h3, 32'h3, 16'h0020, 32'h5000, " R6 reserved code");
    step(1'b0, 2'b00, 32'h3, 32'h3, 16'h0020, 32'h5004, " R6 no branch");
    step(1'b1, 2'b01, 32'h3, 32'h3, 16'h0020, 32'h6000, " R7 stall blocks");
    step(1'b0, 2'b01, 32'h0, 32'h0, 16'hFFFE, 32'h0000_0004, " R9 negative wrap");
    step(1'b0, 2'b00, 32'h0, 32'h0, 16'h0000, 32'hFFFF_FFFC, " R9 seq wrap");
    step(1'b0, 2'b10, 32'h0, 32'h1, 16'h7FFF, 32'hFFFF_FFF0, " R9 fwd wrap");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 2) ? a : $urandom;
      step(($urandom % 6) == 0, 2'($urandom), a, b, 16'($urandom),
           {$urandom} & 32'hFFFF_FFFC, " rnd");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule